// File: doc/BRIEF.md
# Boot Strap Capture and Decoder

This block takes a snapshot of the configuration strap pins once, at the end of reset, and holds it for the rest of the power-on period. The pins it samples are shared with ordinary I/O. After the snapshot is taken, later activity on those pins has no effect on the latched settings. The snapshot is decoded into five settings: the firmware boot source, the source of the first-stage loader, the chain-position configuration code, the routing of inter-chip flow control, and the PCIe reference clocking mode.

From the configuration code the block also derives a role for each of the four serial lanes. A lane is either unused, the USB device lane, part of a PCIe endpoint link, or part of a PCIe root-port link. From that lane map it raises one enable for each kind of controller. Until the snapshot exists, every output carries the default setting, so logic that reads the outputs early sees a coherent configuration.

The control is a two-state machine:
- `ST_ARMED` is entered whenever reset is asserted.
- The transition `ARMED->LOCKED` happens on the first clock edge with reset released. The pins are sampled on that edge.
- `ST_LOCKED` loops on itself until the next reset.

Top module: `boot_strap_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after its release before any clock edge, `cap_valid` is 0 and every decoded output holds the default setting. The default setting is: boot source PCIe (`boot_src`=10), `ldr_from_flash`=0, `cfg_code`=001, `fc_over_pcie`=0, `clk_noncommon`=0, `boot_err`=0, and the lane map for code 001.
- R2: On the first rising clock edge with `rst_n` high, the pins are captured and `cap_valid` becomes 1. It stays 1 until reset is asserted again.
- R3: Once `cap_valid` is 1, changes on any strap pin leave every output unchanged.
- R4: `ldr_from_flash` equals the captured loader pin: 0 selects on-chip ROM, 1 selects QSPI flash.
- R5: `boot_src` follows the captured 2-bit boot pin. The encoding is 00 QSPI flash, 01 USB, 10 PCIe.
- R6: A captured boot pin value of 11 is reserved. It sets `boot_err` to 1 and drives `boot_src` to 10 (PCIe). Any other value gives `boot_err` 0.
- R7: `cfg_code` equals the captured 3-bit code. `lane_roles` places lane i in bits [2i+1:2i], coded 00 unused, 01 USB device, 10 PCIe endpoint, 11 PCIe root port.
- R8: Lane roles for lanes 0/1/2/3 by code:
  - 000: unused / USB / root / root
  - 001 and 111: endpoint / endpoint / root / root
  - 010 and 100: endpoint on all four lanes
  - 011: endpoint / USB / root / root
  - 101 and 110: unused / USB / unused / unused
- R9: `fc_over_pcie` equals the captured flow-control pin: 0 selects GPIO, 1 selects PCIe. `clk_noncommon` equals the captured clock-mode pin: 0 selects common clocking, 1 selects non-common clocking.
- R10: `usb_en`, `pcie_ep_en` and `pcie_rp_en` are each 1 exactly when at least one lane carries the USB, endpoint or root-port role, respectively.
- R11: A new reset re-arms the capture. The next release samples the pins afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_ldr | input | 1 | First-stage loader strap |
| pin_boot | input | 2 | Boot source strap |
| pin_cfg | input | 3 | Chain configuration strap |
| pin_fc | input | 1 | Flow-control routing strap |
| pin_clkm | input | 1 | PCIe clocking mode strap |
| cap_valid | output | 1 | Snapshot taken |
| ldr_from_flash | output | 1 | Loader fetched from QSPI flash |
| boot_src | output | 2 | Decoded firmware source |
| boot_err | output | 1 | Reserved boot value captured |
| cfg_code | output | 3 | Latched configuration code |
| fc_over_pcie | output | 1 | Flow control routed over PCIe |
| clk_noncommon | output | 1 | Non-common clocking selected |
| lane_roles | output | 8 | Two-bit role per lane |
| usb_en | output | 1 | Some lane is the USB device |
| pcie_ep_en | output | 1 | Some lane is a PCIe endpoint |
| pcie_rp_en | output | 1 | Some lane is a PCIe root port |

## Verification
The hardest situation to reach is a reset release with the pins at non-default values, immediately followed by pin changes. This shows both that the capture edge is exactly the first one and that the latch then ignores the pins. The stimulus walks all 32 combinations of configuration code and boot value. Each combination gets its own reset pulse, with the other straps derived from it. Every pin is inverted two cycles after release, and a behavioural model compares all outputs on every falling edge.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

    typedef enum logic [1:0] {
        LANE_OFF = 2'b00,
        LANE_USB = 2'b01,
        LANE_EP  = 2'b10,
        LANE_RP  = 2'b11
    } lane_role_e;

    typedef enum logic [1:0] {
        SRC_FLASH = 2'b00,
        SRC_USB   = 2'b01,
        SRC_PCIE  = 2'b10,
        SRC_RSVD  = 2'b11
    } boot_src_e;

    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_LOCKED = 1'b1
    } latch_state_e;

    typedef struct packed {
        logic       ldr;
        logic [1:0] boot;
        logic [2:0] cfg;
        logic       fc;
        logic       clkm;
    } strap_word_t;

    localparam strap_word_t STRAP_DEFAULT = '{
        ldr:  1'b0,
        boot: 2'b10,
        cfg:  3'b001,
        fc:   1'b0,
        clkm: 1'b0
    };

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import boot_strap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  strap_word_t pins,
    output strap_word_t held,
    output logic        valid
);
    latch_state_e state_q, state_d;
    strap_word_t  word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= STRAP_DEFAULT;
        end else if (state_q == ST_ARMED) begin
            word_q <= pins;
        end
    end

    always_comb begin
        valid = (state_q == ST_LOCKED);
        held  = word_q;
    end
endmodule

// File: rtl/lane_role_map.sv
module lane_role_map
    import boot_strap_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int ROLE_W = 2 * NUM_LANES
) (
    input  logic [2:0]        cfg,
    output logic [ROLE_W-1:0] roles
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_role_e role;
        if (g == 0) begin : g_l0
            always_comb begin
                unique case (cfg)
                    3'b000, 3'b101, 3'b110: role = LANE_OFF;
                    default:                role = LANE_EP;
                endcase
            end
        end else if (g == 1) begin : g_l1
            always_comb begin
                unique case (cfg)
                    3'b001, 3'b010, 3'b100, 3'b111: role = LANE_EP;
                    default:                        role = LANE_USB;
                endcase
            end
        end else begin : g_lhi
            always_comb begin
                unique case (cfg)
                    3'b010, 3'b100: role = LANE_EP;
                    3'b101, 3'b110: role = LANE_OFF;
                    default:        role = LANE_RP;
                endcase
            end
        end
        assign roles[2*g +: 2] = role;
    end
endmodule

// File: rtl/strap_field_decode.sv
module strap_field_decode
    import boot_strap_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int ROLE_W = 2 * NUM_LANES
) (
    input  strap_word_t       held,
    input  logic [ROLE_W-1:0] roles,
    output logic              ldr_from_flash,
    output logic [1:0]        boot_src,
    output logic              boot_err,
    output logic              fc_over_pcie,
    output logic              clk_noncommon,
    output logic              usb_en,
    output logic              pcie_ep_en,
    output logic              pcie_rp_en
);
    always_comb begin
        boot_err = 1'b0;
        unique case (boot_src_e'(held.boot))
            SRC_FLASH: boot_src = SRC_FLASH;
            SRC_USB:   boot_src = SRC_USB;
            SRC_PCIE:  boot_src = SRC_PCIE;
            default: begin
                boot_src = SRC_PCIE;
                boot_err = 1'b1;
            end
        endcase
    end

    always_comb begin
        ldr_from_flash = held.ldr;
        fc_over_pcie   = held.fc;
        clk_noncommon  = held.clkm;
    end

    always_comb begin
        usb_en     = 1'b0;
        pcie_ep_en = 1'b0;
        pcie_rp_en = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (roles[2*i +: 2] == LANE_USB) usb_en     = 1'b1;
            if (roles[2*i +: 2] == LANE_EP)  pcie_ep_en = 1'b1;
            if (roles[2*i +: 2] == LANE_RP)  pcie_rp_en = 1'b1;
        end
    end
endmodule

// File: rtl/boot_strap_unit.sv
module boot_strap_unit
    import boot_strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_ldr,
    input  logic [1:0] pin_boot,
    input  logic [2:0] pin_cfg,
    input  logic       pin_fc,
    input  logic       pin_clkm,
    output logic       cap_valid,
    output logic       ldr_from_flash,
    output logic [1:0] boot_src,
    output logic       boot_err,
    output logic [2:0] cfg_code,
    output logic       fc_over_pcie,
    output logic       clk_noncommon,
    output logic [7:0] lane_roles,
    output logic       usb_en,
    output logic       pcie_ep_en,
    output logic       pcie_rp_en
);
    localparam int NUM_LANES = 4;

    strap_word_t pins_w, held_w;

    assign pins_w = '{ldr: pin_ldr, boot: pin_boot, cfg: pin_cfg,
                      fc: pin_fc, clkm: pin_clkm};

    strap_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins_w),
        .held  (held_w),
        .valid (cap_valid)
    );

    assign cfg_code = held_w.cfg;

    lane_role_map #(.NUM_LANES(NUM_LANES)) u_map (
        .cfg   (held_w.cfg),
        .roles (lane_roles)
    );

    strap_field_decode #(.NUM_LANES(NUM_LANES)) u_dec (
        .held           (held_w),
        .roles          (lane_roles),
        .ldr_from_flash (ldr_from_flash),
        .boot_src       (boot_src),
        .boot_err       (boot_err),
        .fc_over_pcie   (fc_over_pcie),
        .clk_noncommon  (clk_noncommon),
        .usb_en         (usb_en),
        .pcie_ep_en     (pcie_ep_en),
        .pcie_rp_en     (pcie_rp_en)
    );
endmodule

// File: rtl/boot_strap_unit_chk.sv
module boot_strap_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_ldr,
    input logic [1:0] pin_boot,
    input logic [2:0] pin_cfg,
    input logic       pin_fc,
    input logic       pin_clkm,
    input logic       cap_valid,
    input logic       ldr_from_flash,
    input logic [1:0] boot_src,
    input logic       boot_err,
    input logic [2:0] cfg_code,
    input logic       fc_over_pcie,
    input logic       clk_noncommon,
    input logic [7:0] lane_roles,
    input logic       usb_en,
    input logic       pcie_ep_en,
    input logic       pcie_rp_en
);
    p_default_before_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> (boot_src == 2'b10 && cfg_code == 3'b001 && !boot_err &&
                        lane_roles == 8'b11_11_10_10));

    p_capture_next_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> cap_valid);

    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> cap_valid);

    p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> ($stable(lane_roles) && $stable(boot_src) && $stable(cfg_code) &&
                       $stable(ldr_from_flash) && $stable(fc_over_pcie) &&
                       $stable(clk_noncommon) && $stable(boot_err)));

    p_reserved_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> boot_src == 2'b10);

    p_capture_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> cfg_code == $past(pin_cfg));

    p_usb_single_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lane_roles[7:6] == 2'b01, lane_roles[5:4] == 2'b01,
                    lane_roles[3:2] == 2'b01, lane_roles[1:0] == 2'b01}) <= 1);

    p_usb_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        usb_en == (lane_roles[3:2] == 2'b01));
endmodule

bind boot_strap_unit boot_strap_unit_chk u_chk (.*);

// File: tb/boot_strap_unit_bench.sv
module boot_strap_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_ldr = 1'b0, pin_fc = 1'b0, pin_clkm = 1'b0;
    logic [1:0] pin_boot = 2'b00;
    logic [2:0] pin_cfg = 3'b000;
    logic cap_valid, ldr_from_flash, boot_err, fc_over_pcie, clk_noncommon;
    logic usb_en, pcie_ep_en, pcie_rp_en;
    logic [1:0] boot_src;
    logic [2:0] cfg_code;
    logic [7:0] lane_roles;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_strap_unit u_boot_strap_unit (.*);

    // behavioural reference state
    bit m_valid;
    int m_ldr, m_boot, m_cfg, m_fc, m_clkm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid = 0; m_ldr = 0; m_boot = 2; m_cfg = 1; m_fc = 0; m_clkm = 0;
        end else if (!m_valid) begin
            m_valid = 1;
            m_ldr = pin_ldr; m_boot = pin_boot; m_cfg = pin_cfg;
            m_fc = pin_fc; m_clkm = pin_clkm;
        end
    end

    function automatic logic [7:0] exp_roles(int code);
        case (code)
            0: return 8'b11_11_01_00;
            1: return 8'b11_11_10_10;
            2: return 8'b10_10_10_10;
            3: return 8'b11_11_01_10;
            4: return 8'b10_10_10_10;
            5: return 8'b00_00_01_00;
            6: return 8'b00_00_01_00;
            default: return 8'b11_11_10_10;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] r;
        bit eu, ee, er;
        r = exp_roles(m_cfg);
        eu = 0; ee = 0; er = 0;
        for (int i = 0; i < 4; i++) begin
            if (r[2*i +: 2] == 2'b01) eu = 1;
            if (r[2*i +: 2] == 2'b10) ee = 1;
            if (r[2*i +: 2] == 2'b11) er = 1;
        end
        if (!rst_n) chk("R1 reset valid", cap_valid, 0);
        chk("R2 cap_valid", cap_valid, m_valid);
        chk("R4 ldr_from_flash", ldr_from_flash, m_ldr);
        chk("R5 boot_src", boot_src, (m_boot == 3) ? 2 : m_boot);
        chk("R6 boot_err", boot_err, m_boot == 3);
        chk("R7 cfg_code", cfg_code, m_cfg);
        chk("R8 lane_roles", lane_roles, r);
        chk("R9 fc_over_pcie", fc_over_pcie, m_fc);
        chk("R9 clk_noncommon", clk_noncommon, m_clkm);
        chk("R10 usb_en", usb_en, eu);
        chk("R10 pcie_ep_en", pcie_ep_en, ee);
        chk("R10 pcie_rp_en", pcie_rp_en, er);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset with non-default pins still shows defaults
        pin_boot = 2'b11; pin_cfg = 3'b110; pin_ldr = 1; pin_fc = 1; pin_clkm = 1;
        step(3);
        rst_n = 1;
        step(1);
        // R3: pins toggled after capture are ignored
        pin_boot = 2'b00; pin_cfg = 3'b000; pin_ldr = 0; pin_fc = 0; pin_clkm = 0;
        step(3);
        // R11: every combination through its own reset and release
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 4; b++) begin
                rst_n = 0;
                pin_cfg = 3'(c); pin_boot = 2'(b);
                pin_ldr = c[0] ^ b[0]; pin_fc = c[1]; pin_clkm = b[1] ^ c[2];
                step(2);
                rst_n = 1;
                step(2);
                pin_cfg = ~pin_cfg; pin_boot = ~pin_boot;
                pin_ldr = ~pin_ldr; pin_fc = ~pin_fc; pin_clkm = ~pin_clkm;
                step(3);
            end
        end
        finish_run();
    end
endmodule